// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the master side of an I2C link that a processor drives one byte at a time. The processor opens a transaction with a start command. After that it touches only one data register. A write of that register hands a byte to the engine, which shifts it out most significant bit first and then samples the slave's acknowledge. A read returns the byte received last and at once starts clocking in the next byte. Each finished byte sets a done flag that the processor clears. A stop command closes the transaction.

SCL comes from a fixed divider. Each bit time has four equal quarters: two with SCL low, then two with SCL high. SDA only changes during the second low quarter, except for the start and stop conditions, which change SDA while SCL is high. Both lines are open-drain. The block drives a line low and otherwise releases it. Reads, writes and commands that arrive in the wrong state do not change the bus.

Top module: `i2cm_engine`

## Requirements
- R1: After reset both bus lines are released, and `done`, `nack`, `session` and `busy` are 0.
- R2: A `cmd_start` pulse while idle makes a start condition: SDA falls while SCL is high. After that SCL is held low, `session` is 1 and `busy` is 0.
- R3: A `data_wr` pulse while the session is waiting sends `data_wdata` on SDA, most significant bit first, one bit per SCL pulse. A ninth SCL pulse follows for the acknowledge.
- R4: `done` goes to 1 when the ninth SCL pulse of a byte ends. It stays 1 until a `done_clr` pulse clears it.
- R5: After a transmitted byte, `nack` is 0 if the slave held SDA low during the ninth SCL pulse and 1 if SDA was high.
- R6: A `data_rd` pulse while the session is waiting clocks in eight bits from SDA, most significant bit first. When `done` rises, `data_rdata` holds that byte.
- R7: In a receive byte the master pulls SDA low in the ninth bit (ACK) when `rx_last` was 0 at the `data_rd` pulse. It releases SDA (NACK) when `rx_last` was 1.
- R8: A `cmd_stop` pulse while the session is waiting makes a stop condition: SDA rises while SCL is high. After that both lines are released and `session` is 0.
- R9: While no session is open, `data_wr` and `data_rd` produce no SCL edge and do not set `done`.
- R10: SDA never changes while SCL is high, except in start and stop conditions.
- R11: `data_wr` and `data_rd` pulses that arrive while a byte is in progress are ignored. The byte on the bus is not changed and no further byte follows.
- R12: Every SCL high time in a byte lasts 2 x `QUARTER_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | One-cycle request to open a session with a start condition |
| cmd_stop | input | 1 | One-cycle request to close the session with a stop condition |
| rx_last | input | 1 | Sampled on `data_rd`: 1 answers the received byte with NACK |
| data_wr | input | 1 | One-cycle write strobe of the data register |
| data_wdata | input | 8 | Byte to transmit |
| data_rd | input | 1 | One-cycle read strobe of the data register |
| data_rdata | output | 8 | Byte received last |
| done_clr | input | 1 | One-cycle clear of the done flag |
| done | output | 1 | Byte-done flag |
| nack | output | 1 | 1 when the last transmitted byte got no acknowledge |
| session | output | 1 | 1 between start and the end of stop |
| busy | output | 1 | 1 while a start, byte or stop is running on the bus |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
If the sequencer's bit counter or phase counter slips, the wrong number of SCL pulses appears in the very next byte. A slave then sees a shifted byte, or `done` rises one bit time early or late. A stale shift register shows up as a wrong `data_rdata` or a wrong value captured by the slave as soon as that byte completes. If the drive register for SDA updates in the wrong quarter, SDA moves while SCL is high. A bus monitor sees this as a spurious start or stop within the same bit time. A bad state decode after stop leaves a line pulled low, and the idle bus shows it straight away.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W    = 8;
    localparam int SLOT_W    = 4;
    localparam int ACK_SLOT  = BYTE_W;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [1:0]        phase_t;

    localparam phase_t PH_LOW_A  = 2'd0;
    localparam phase_t PH_LOW_B  = 2'd1;
    localparam phase_t PH_HIGH_A = 2'd2;
    localparam phase_t PH_HIGH_B = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_BYTE,
        ST_STOP
    } seq_state_e;

    typedef enum logic {
        DIR_TX,
        DIR_RX
    } byte_dir_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } bus_drive_t;

    typedef struct packed {
        logic byte_end;
        logic ack_valid;
        logic ack_nack;
    } seq_event_t;

    // SCL level for a given sequencer state and quarter of the bit time
    function automatic logic scl_low_for(seq_state_e st, phase_t ph);
        logic low;
        case (st)
            ST_START: low = (ph == PH_HIGH_B);
            ST_HOLD:  low = 1'b1;
            ST_BYTE,
            ST_STOP:  low = (ph[1] == 1'b0);
            default:  low = 1'b0;
        endcase
        return low;
    endfunction

endpackage

// File: rtl/i2cm_divider.sv
module i2cm_divider #(
    parameter int QUARTER_DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER_DIV > 1) ? $clog2(QUARTER_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (QUARTER_DIV > 1) begin : g_gap_check
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                $past(tick) |-> !tick); // R12
        end
    endgenerate

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              data_rd,
    input  logic              rx_last,
    input  logic              sda_in,
    output logic              run,
    output bus_drive_t        bus_o,
    output seq_event_t        ev_o,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              session
);
    seq_state_e        st_q;
    phase_t            ph_q;
    slot_t             slot_q;
    byte_dir_e         dir_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] rx_q;
    logic              sda_low_q;
    logic              last_q;

    logic data_slot;
    logic ack_slot;

    assign data_slot = (slot_q < slot_t'(ACK_SLOT));
    assign ack_slot  = (slot_q == slot_t'(ACK_SLOT));

    assign run     = (st_q == ST_START) || (st_q == ST_BYTE) || (st_q == ST_STOP);
    assign session = (st_q != ST_IDLE);
    assign rx_byte = rx_q;

    assign bus_o.scl_low = scl_low_for(st_q, ph_q);
    assign bus_o.sda_low = sda_low_q;

    assign ev_o.byte_end  = (st_q == ST_BYTE) && tick && (ph_q == PH_HIGH_B) && ack_slot;
    assign ev_o.ack_valid = (st_q == ST_BYTE) && tick && (ph_q == PH_HIGH_A) && ack_slot
                            && (dir_q == DIR_TX);
    assign ev_o.ack_nack  = sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ph_q      <= PH_LOW_A;
            slot_q    <= '0;
            dir_q     <= DIR_TX;
            shreg_q   <= '0;
            rx_q      <= '0;
            sda_low_q <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    ph_q <= PH_LOW_A;
                    if (cmd_start) begin
                        st_q <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        ph_q <= ph_q + 1'b1;
                        if (ph_q == PH_LOW_B) begin
                            sda_low_q <= 1'b1;
                        end
                        if (ph_q == PH_HIGH_B) begin
                            st_q <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    ph_q   <= PH_LOW_A;
                    slot_q <= '0;
                    if (cmd_stop) begin
                        st_q <= ST_STOP;
                    end else if (data_wr) begin
                        st_q    <= ST_BYTE;
                        dir_q   <= DIR_TX;
                        shreg_q <= data_wdata;
                    end else if (data_rd) begin
                        st_q   <= ST_BYTE;
                        dir_q  <= DIR_RX;
                        last_q <= rx_last;
                    end
                end
                ST_BYTE: begin
                    if (tick) begin
                        ph_q <= ph_q + 1'b1;
                        case (ph_q)
                            PH_LOW_A: begin
                                if (data_slot) begin
                                    if (dir_q == DIR_TX) begin
                                        sda_low_q <= ~shreg_q[BYTE_W-1];
                                        shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
                                    end else begin
                                        sda_low_q <= 1'b0;
                                    end
                                end else begin
                                    sda_low_q <= (dir_q == DIR_RX) && !last_q;
                                end
                            end
                            PH_HIGH_A: begin
                                if (data_slot && (dir_q == DIR_RX)) begin
                                    shreg_q <= {shreg_q[BYTE_W-2:0], sda_in};
                                end
                            end
                            PH_HIGH_B: begin
                                if (ack_slot) begin
                                    st_q   <= ST_HOLD;
                                    slot_q <= '0;
                                    if (dir_q == DIR_RX) begin
                                        rx_q <= shreg_q;
                                    end
                                end else begin
                                    slot_q <= slot_q + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        ph_q <= ph_q + 1'b1;
                        if (ph_q == PH_LOW_A) begin
                            sda_low_q <= 1'b1;
                        end
                        if (ph_q == PH_HIGH_A) begin
                            sda_low_q <= 1'b0;
                        end
                        if (ph_q == PH_HIGH_B) begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BYTE && $past(st_q == ST_BYTE) && !bus_o.scl_low && $past(!bus_o.scl_low))
        |-> $stable(bus_o.sda_low)); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (!bus_o.scl_low && !bus_o.sda_low)); // R1

    AST_BYTE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BYTE && $past(st_q != ST_BYTE))
        |-> ($past(st_q == ST_HOLD) && $past(data_wr || data_rd))); // R9

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_q <= slot_t'(ACK_SLOT)); // R3

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_event_t ev_i,
    input  logic       done_clr,
    output logic       done,
    output logic       nack
);
    logic done_q;
    logic nack_q;

    assign done = done_q;
    assign nack = nack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            if (ev_i.byte_end) begin
                done_q <= 1'b1;
            end else if (done_clr) begin
                done_q <= 1'b0;
            end
            if (ev_i.ack_valid) begin
                nack_q <= ev_i.ack_nack;
            end
        end
    end

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(ev_i.byte_end)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(done_q) && !$past(done_clr)) |-> done_q); // R4

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int QUARTER_DIV = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       rx_last,
    input  logic       data_wr,
    input  logic [7:0] data_wdata,
    input  logic       data_rd,
    output logic [7:0] data_rdata,
    input  logic       done_clr,
    output logic       done,
    output logic       nack,
    output logic       session,
    output logic       busy,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    logic       run;
    logic       tick;
    bus_drive_t bus;
    seq_event_t ev;

    i2cm_divider #(.QUARTER_DIV(QUARTER_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    i2cm_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .data_rd    (data_rd),
        .rx_last    (rx_last),
        .sda_in     (sda_in),
        .run        (run),
        .bus_o      (bus),
        .ev_o       (ev),
        .rx_byte    (data_rdata),
        .session    (session)
    );

    i2cm_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .done_clr (done_clr),
        .done     (done),
        .nack     (nack)
    );

    assign busy          = run;
    assign scl_drive_low = bus.scl_low;
    assign sda_drive_low = bus.sda_low;

endmodule

// File: tb/i2cm_engine_test.sv
module i2cm_engine_test;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       rx_last = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic       data_rd = 1'b0;
    logic [7:0] data_rdata;
    logic       done_clr = 1'b0;
    logic       done;
    logic       nack;
    logic       session;
    logic       busy;
    logic       scl_drive_low;
    logic       sda_drive_low;

    logic       s_drive = 1'b0;
    logic       scl_bus;
    logic       sda_bus;

    assign scl_bus = !scl_drive_low;
    assign sda_bus = !(sda_drive_low || s_drive);

    always #10 clk = ~clk;

    i2cm_engine #(.QUARTER_DIV(DIV)) uut (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .rx_last       (rx_last),
        .data_wr       (data_wr),
        .data_wdata    (data_wdata),
        .data_rd       (data_rd),
        .data_rdata    (data_rdata),
        .done_clr      (done_clr),
        .done          (done),
        .nack          (nack),
        .session       (session),
        .busy          (busy),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .sda_in        (sda_bus)
    );

    int checks = 0;
    int fails  = 0;

    // slave model configuration (set by the bench while SCL is held low)
    logic       mode_tx = 1'b0;
    logic       ack_en  = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_arm  = 1'b0;

    // slave model observations
    logic       arm_seen = 1'b0;
    logic       scl_p = 1'b1;
    logic       sda_p = 1'b1;
    int         bitcnt = 0;
    logic [7:0] shift_in = 8'h00;
    logic [7:0] got_byte = 8'h00;
    logic       m_ack_seen = 1'b0;
    int         starts = 0;
    int         stops = 0;
    int         hi_toggles = 0;
    int         scl_falls = 0;
    int         high_len = 0;
    int         last_high = 0;

    always @(posedge clk) begin
        if (tx_arm != arm_seen) begin
            arm_seen <= tx_arm;
            s_drive  <= !tx_byte[7];
        end
        if (scl_bus && scl_p && (sda_bus != sda_p)) begin
            hi_toggles = hi_toggles + 1;
        end
        if (scl_bus && scl_p && sda_p && !sda_bus) begin
            starts = starts + 1;
            bitcnt = 0;
        end else if (scl_bus && scl_p && !sda_p && sda_bus) begin
            stops = stops + 1;
        end else if (scl_bus && !scl_p) begin
            high_len = 0;
            if (bitcnt < 8) begin
                if (!mode_tx) shift_in = {shift_in[6:0], sda_bus};
            end else begin
                if (mode_tx) m_ack_seen = !sda_bus;
                else         got_byte = shift_in;
            end
            bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
        end else if (!scl_bus && scl_p) begin
            scl_falls = scl_falls + 1;
            last_high = high_len;
            if (mode_tx && bitcnt < 8) s_drive <= !tx_byte[7-bitcnt];
            else                       s_drive <= (!mode_tx && bitcnt == 8 && ack_en);
        end
        if (scl_bus) high_len = high_len + 1;
        scl_p = scl_bus;
        sda_p = sda_bus;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        @(negedge clk); data_wdata = v; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_rd(input logic last);
        @(negedge clk); rx_last = last; data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(req, done, 1'b1);
    endtask

    task automatic clear_done;
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic arm_slave_tx(input logic [7:0] v);
        @(negedge clk); mode_tx = 1'b1; tx_byte = v; tx_arm = ~tx_arm;
        @(negedge clk);
    endtask

    // {read, data, flag}: write -> flag = slave acks; read -> flag = last byte
    localparam logic [9:0] VEC [7] = '{
        {1'b0, 8'hA5, 1'b1},
        {1'b0, 8'h3C, 1'b0},
        {1'b0, 8'hFF, 1'b1},
        {1'b0, 8'h00, 1'b1},
        {1'b1, 8'h96, 1'b0},
        {1'b1, 8'h01, 1'b0},
        {1'b1, 8'hE7, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int falls_before;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", scl_drive_low, 1'b0);
        chk("R1 sda", sda_drive_low, 1'b0);
        chk("R1 done/nack", {done, nack}, 2'b00);
        chk("R1 session/busy", {session, busy}, 2'b00);

        // R9 accesses outside a session
        pulse_wr(8'h55);
        pulse_rd(1'b0);
        repeat (40) @(negedge clk);
        chk("R9 no scl edge", scl_falls, 0);
        chk("R9 no done", done, 1'b0);
        chk("R9 no session", session, 1'b0);

        // R2 start
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (4 * DIV + 4) @(negedge clk);
        chk("R2 start seen", starts, 1);
        chk("R2 scl held low", scl_drive_low, 1'b1);
        chk("R2 session", {session, busy}, 2'b10);

        for (int i = 0; i < 7; i++) begin
            if (!VEC[i][9]) begin
                @(negedge clk); mode_tx = 1'b0; ack_en = VEC[i][0];
                pulse_wr(VEC[i][8:1]);
                wait_done("R4 done after tx");
                chk("R3 slave got byte", got_byte, VEC[i][8:1]);
                chk("R5 nack", nack, !VEC[i][0]);
            end else begin
                arm_slave_tx(VEC[i][8:1]);
                pulse_rd(VEC[i][0]);
                wait_done("R4 done after rx");
                chk("R6 rdata", data_rdata, VEC[i][8:1]);
                chk("R7 master ack", m_ack_seen, !VEC[i][0]);
            end
            clear_done;
            chk("R4 cleared", done, 1'b0);
            chk("R12 scl high time", last_high, 2 * DIV);
        end

        // R11 accesses during a byte are ignored
        @(negedge clk); mode_tx = 1'b0; ack_en = 1'b1;
        pulse_wr(8'h5A);
        repeat (20) @(negedge clk);
        pulse_wr(8'hC3);
        pulse_rd(1'b0);
        wait_done("R11 done");
        chk("R11 byte unchanged", got_byte, 8'h5A);
        clear_done;
        falls_before = scl_falls;
        repeat (200) @(negedge clk);
        chk("R11 no extra byte", {busy, done}, 2'b00);
        chk("R11 no extra scl", scl_falls, falls_before);

        // R8 stop
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        repeat (4 * DIV + 4) @(negedge clk);
        chk("R8 stop seen", stops, 1);
        chk("R8 released", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R8 session end", session, 1'b0);

        // R9 again after stop
        falls_before = scl_falls;
        pulse_wr(8'h81);
        repeat (40) @(negedge clk);
        chk("R9 after stop", scl_falls, falls_before);

        // R10 only start/stop move SDA with SCL high
        chk("R10 sda while scl high", hi_toggles, starts + stops);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule